// File: doc/BRIEF.md
# Split-Capable Word Load/Store Unit

This unit carries out one byte-addressed 32-bit load or store at a time against a memory port that only moves whole 32-bit words at word-aligned addresses. The effective address is the base value plus a signed 11-bit immediate. The sum is formed before any memory access and wraps within the 24-bit address space. When the effective address is not a multiple of four, the unit splits the access into two aligned word transactions. It issues the lower word first and then the following word. It then merges the load bytes, or spreads the store bytes across lanes, in little-endian order.

Each request comes with a condition-pass flag. When that flag is low, the request is retired without touching memory and the result is marked as skipped. Every memory response carries a fault flag, which the memory raises for an invalid, unreadable or absent word. A fault on either transaction ends the operation, and the result is reported with the fault flag set and zero data. The unit holds one request at a time. `req_ready` is high only while the unit is idle, and each accepted request yields exactly one single-cycle result.

Top module: `lsu_split`

## Requirements
- R1: The effective address is `req_base` plus `req_off` sign-extended to 24 bits, modulo 2^24. The word address of the first transaction is the effective address with bits [1:0] cleared.
- R2: An access whose effective address has bits [1:0] equal to 0 makes exactly one memory transaction, with `mem_addr[1:0]` = 0. A load uses `mem_be` = 4'b1111, and a store uses `mem_be` = 4'b1111 with `mem_wdata` equal to the store data.
- R3: An access whose effective address has bits [1:0] not equal to 0 makes two transactions. The first goes to the word holding the effective address and the second to the next word address, which wraps from 0xFFFFFC to 0x000000. The second is issued only after the first response.
- R4: A load returns the four bytes at effective addresses ea, ea+1, ea+2 and ea+3. Byte ea lands in `res_data[7:0]` and byte ea+3 in `res_data[31:24]`. Each byte is taken from lane (address mod 4) of its memory word.
- R5: A store sets `mem_be` bit k only for lane k of a byte inside the 4-byte window ea..ea+3. Each written byte holds the matching store-data byte, with bits [7:0] going to address ea. Bytes outside the window keep their prior contents.
- R6: A request accepted with `req_cond_ok` = 0 makes no memory transaction. It yields a result with `res_skip` = 1, `res_fault` = 0 and `res_data` = 0. Memory contents are left unchanged.
- R7: A fault response on the first transaction ends the operation with no second transaction. The result has `res_fault` = 1, `res_skip` = 0 and `res_data` = 0.
- R8: A fault on the second transaction of a split access yields `res_fault` = 1 and `res_data` = 0. For a store, the first word's write has already taken effect.
- R9: `req_ready` is low from acceptance until the result cycle has passed. `mem_req` lasts one cycle per transaction. `res_valid` pulses for one cycle per accepted request.
- R10: After reset, `req_ready` = 1, `mem_req` = 0 and `res_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle; a request is taken on this edge |
| req_store | input | 1 | 1 = store, 0 = load |
| req_cond_ok | input | 1 | Condition satisfied; 0 squashes the access |
| req_base | input | 24 | Base address value |
| req_off | input | 11 | Signed immediate offset |
| req_wdata | input | 32 | Store data |
| mem_req | output | 1 | One-cycle memory transaction strobe |
| mem_we | output | 1 | Transaction is a write |
| mem_addr | output | 24 | Word-aligned byte address |
| mem_be | output | 4 | Per-lane byte enables |
| mem_wdata | output | 32 | Write data by lane |
| mem_ack | input | 1 | One-cycle response strobe |
| mem_rdata | input | 32 | Read word |
| mem_fault | input | 1 | Response reports an invalid access |
| res_valid | output | 1 | Result strobe |
| res_skip | output | 1 | Access was squashed by its condition |
| res_fault | output | 1 | Access ended with a memory fault |
| res_data | output | 32 | Load result (0 for stores, skips and faults) |

## Verification
The assertions assume that the memory answers each `mem_req` with exactly one `mem_ack`, never earlier than the cycle after the strobe, and never while no transaction is outstanding. The bench's memory model meets this assumption: it records each strobe and answers it after a latency that cycles through 1, 2 and 3 cycles. The bench offers a new request only after the previous result has been retired. Its fault map marks two fixed words, chosen so that split accesses can fault on either the first or the second half.

// File: rtl/lsu_split.sv
module lsu_split #(
  parameter int AW = 24,
  parameter int DW = 32,
  parameter int OW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_store,
  input  logic          req_cond_ok,
  input  logic [AW-1:0] req_base,
  input  logic [OW-1:0] req_off,
  input  logic [DW-1:0] req_wdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW/8-1:0] mem_be,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_fault,
  output logic          res_valid,
  output logic          res_skip,
  output logic          res_fault,
  output logic [DW-1:0] res_data
);
  localparam int NB  = DW / 8;
  localparam int BW  = $clog2(NB);
  localparam int WAW = AW - BW;
  localparam int SW  = BW + 3;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} state_t;

  state_t        st;
  logic          second, is_st, flt, skip;
  logic [AW-1:0] ea;
  logic [DW-1:0] wd, lo, hi;

  logic [BW-1:0]   lane;
  logic [SW-1:0]   sh;
  logic            split;
  logic [2*DW-1:0] wide_d;
  logic [2*NB-1:0] wide_be;

  assign lane    = ea[BW-1:0];
  assign sh      = {lane, 3'b000};
  assign split   = |lane;
  assign wide_d  = {{DW{1'b0}}, wd} << sh;
  assign wide_be = {{NB{1'b0}}, {NB{1'b1}}} << lane;

  assign req_ready = (st == S_IDLE);
  assign mem_req   = (st == S_ISSUE);
  assign mem_we    = is_st;
  assign mem_addr  = {ea[AW-1:BW] + WAW'(second), {BW{1'b0}}};
  assign mem_be    = !is_st ? {NB{1'b1}} : (second ? wide_be[2*NB-1:NB] : wide_be[NB-1:0]);
  assign mem_wdata = !is_st ? '0 : (second ? wide_d[2*DW-1:DW] : wide_d[DW-1:0]);

  assign res_valid = (st == S_DONE);
  assign res_skip  = res_valid && skip;
  assign res_fault = res_valid && flt;
  assign res_data  = (res_valid && !is_st && !flt && !skip) ? DW'({hi, lo} >> sh) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      second <= 1'b0;
      is_st  <= 1'b0;
      flt    <= 1'b0;
      skip   <= 1'b0;
      ea     <= '0;
      wd     <= '0;
      lo     <= '0;
      hi     <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          ea     <= req_base + {{(AW-OW){req_off[OW-1]}}, req_off};
          wd     <= req_wdata;
          is_st  <= req_store;
          second <= 1'b0;
          flt    <= 1'b0;
          skip   <= !req_cond_ok;
          st     <= req_cond_ok ? S_ISSUE : S_DONE;
        end
        S_ISSUE: st <= S_WAIT;
        S_WAIT: if (mem_ack) begin
          if (second) hi <= mem_rdata;
          else        lo <= mem_rdata;
          if (mem_fault) begin
            flt <= 1'b1;
            st  <= S_DONE;
          end else if (!second && split) begin
            second <= 1'b1;
            st     <= S_ISSUE;
          end else begin
            st <= S_DONE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lsu_split_chk.sv
module lsu_split_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          mem_req,
  input logic          mem_we,
  input logic [1:0]    mem_addr_lo,
  input logic [DW/8-1:0] mem_be,
  input logic          res_valid,
  input logic          res_skip,
  input logic          res_fault,
  input logic [DW-1:0] res_data
);
  logic [2:0] txn_n;

  always_ff @(posedge clk) begin
    if (!rst_n) txn_n <= '0;
    else if (req_valid && req_ready) txn_n <= '0;
    else if (mem_req) txn_n <= txn_n + 3'd1;
  end

  p_word_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr_lo == 2'b00);

  p_at_most_two_r3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> txn_n <= 3'd2);

  p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  p_be_contiguous_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_be != '0 &&
      ((mem_be + (mem_be & (~mem_be + 1'b1))) & mem_be) == '0 &&
      (mem_be[0] || mem_be[DW/8-1]));

  p_skip_no_mem_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_skip |-> txn_n == 3'd0);

  p_fault_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_fault |-> res_data == '0 && !res_skip);

  p_busy_no_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);

  p_result_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
endmodule

bind lsu_split lsu_split_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr_lo(mem_addr[1:0]),
  .mem_be(mem_be), .res_valid(res_valid), .res_skip(res_skip),
  .res_fault(res_fault), .res_data(res_data)
);

// File: tb/sim_lsu_split.sv
`timescale 1ns/1ps
module sim_lsu_split;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_store = 1'b0, req_cond_ok = 1'b0;
  logic [23:0] req_base = '0;
  logic [10:0] req_off = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, mem_req, mem_we;
  logic [23:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic        mem_ack = 1'b0, mem_fault = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        res_valid, res_skip, res_fault;
  logic [31:0] res_data;

  always #2 clk = ~clk;

  lsu_split u0 (.*);

  typedef struct packed { logic we; logic [23:0] addr; logic [3:0] be; logic [31:0] d; } txn_t;
  typedef struct packed { logic skip; logic fault; logic [31:0] data; } res_t;

  txn_t  exp_txn[$];
  res_t  exp_res[$];
  string exp_tag[$];
  int    checks = 0, fails = 0;
  logic [31:0] mem [int unsigned];

  function automatic logic [31:0] init_word(input int unsigned w);
    return (w * 32'h9E3779B1) ^ 32'h13572468;
  endfunction
  function automatic logic [31:0] rd_word(input int unsigned w);
    return mem.exists(w) ? mem[w] : init_word(w);
  endfunction
  function automatic bit is_fault(input int unsigned w);
    return (w == 32'h1000) || (w == 32'h2000);
  endfunction
  function automatic logic [7:0] byte_at(input logic [23:0] a);
    logic [31:0] wv;
    wv = rd_word({10'd0, a[23:2]});
    return wv[8*a[1:0] +: 8];
  endfunction

  // memory model: answers each strobe after 1..3 cycles
  int unsigned lat_sel = 0, wait_n = 0;
  bit          pend = 0, pf = 0;
  logic [31:0] pd = '0;
  always @(negedge clk) begin
    mem_ack = 1'b0;
    if (pend) begin
      if (wait_n == 0) begin
        mem_ack = 1'b1; mem_fault = pf; mem_rdata = pd; pend = 0;
      end else wait_n = wait_n - 1;
    end
    if (rst_n && mem_req) begin
      int unsigned w;
      logic [31:0] cur;
      w   = {10'd0, mem_addr[23:2]};
      pf  = is_fault(w);
      cur = rd_word(w);
      pd  = pf ? 32'hDEAD_BEEF : cur;
      if (mem_we && !pf) begin
        for (int k = 0; k < 4; k++) if (mem_be[k]) cur[8*k +: 8] = mem_wdata[8*k +: 8];
        mem[w] = cur;
      end
      pend = 1; wait_n = lat_sel; lat_sel = (lat_sel + 1) % 3;
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && mem_req) begin
      txn_t e;
      checks++;
      if (exp_txn.size() == 0) begin
        fails++;
        $display("FAIL R3 unexpected transaction addr=%h be=%h we=%b, expected none", mem_addr, mem_be, mem_we);
      end else begin
        e = exp_txn.pop_front();
        if (mem_we !== e.we || mem_addr !== e.addr || mem_be !== e.be ||
            (e.we && mem_wdata !== e.d) || req_ready !== 1'b0) begin
          fails++;
          $display("FAIL %s txn: we=%b addr=%h be=%h d=%h rdy=%b, expected we=%b addr=%h be=%h d=%h rdy=0",
                   exp_tag.size() ? exp_tag[0] : "R9", mem_we, mem_addr, mem_be, mem_wdata, req_ready,
                   e.we, e.addr, e.be, e.d);
        end
      end
    end
    if (rst_n && res_valid) begin
      res_t e;
      string t;
      checks++;
      if (exp_res.size() == 0) begin
        fails++;
        $display("FAIL R9 unexpected result data=%h, expected none", res_data);
      end else begin
        e = exp_res.pop_front();
        t = exp_tag.pop_front();
        if (res_skip !== e.skip || res_fault !== e.fault || res_data !== e.data || exp_txn.size() != 0) begin
          fails++;
          $display("FAIL %s result: skip=%b fault=%b data=%h missing_txn=%0d, expected skip=%b fault=%b data=%h missing_txn=0",
                   t, res_skip, res_fault, res_data, exp_txn.size(), e.skip, e.fault, e.data);
          exp_txn.delete();
        end
      end
    end
  end

  task automatic do_op(input bit st, input bit ok, input logic [23:0] base,
                       input logic [10:0] off, input logic [31:0] wd, input string tag);
    logic [23:0] ea, a;
    logic [21:0] w0, w1;
    logic [3:0]  be0, be1;
    logic [31:0] d0, d1, ld;
    bit f0, f1, sp;
    res_t r;
    ea = base + {{13{off[10]}}, off};
    w0 = ea[23:2];
    w1 = w0 + 22'd1;
    sp = (ea[1:0] != 2'b00);
    f0 = is_fault({10'd0, w0});
    f1 = sp && is_fault({10'd0, w1});
    be0 = '0; be1 = '0; d0 = '0; d1 = '0; ld = '0;
    for (int i = 0; i < 4; i++) begin
      a = ea + 24'(i);
      ld[8*i +: 8] = byte_at(a);
      if (a[23:2] == w0) begin be0[a[1:0]] = 1'b1; d0[8*a[1:0] +: 8] = wd[8*i +: 8]; end
      else               begin be1[a[1:0]] = 1'b1; d1[8*a[1:0] +: 8] = wd[8*i +: 8]; end
    end
    if (!ok) r = '{skip: 1'b1, fault: 1'b0, data: 32'h0};
    else begin
      exp_txn.push_back(st ? txn_t'{1'b1, {w0, 2'b00}, be0, d0} : txn_t'{1'b0, {w0, 2'b00}, 4'hF, 32'h0});
      if (sp && !f0)
        exp_txn.push_back(st ? txn_t'{1'b1, {w1, 2'b00}, be1, d1} : txn_t'{1'b0, {w1, 2'b00}, 4'hF, 32'h0});
      r = '{skip: 1'b0, fault: f0 || f1, data: (st || f0 || f1) ? 32'h0 : ld};
    end
    exp_res.push_back(r);
    exp_tag.push_back(tag);
    @(negedge clk);
    req_valid = 1'b1; req_store = st; req_cond_ok = ok;
    req_base = base; req_off = off; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (exp_res.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (req_ready !== 1'b1 || mem_req !== 1'b0 || res_valid !== 1'b0) begin
      fails++;
      $display("FAIL R10 reset: ready=%b mem_req=%b res_valid=%b, expected 1 0 0", req_ready, mem_req, res_valid);
    end
    do_op(0, 1, 24'h000100, 11'h000, 0, "R2 aligned load");
    do_op(0, 1, 24'h000100, 11'h010, 0, "R1 positive offset");
    do_op(0, 1, 24'h000100, 11'h7FC, 0, "R1 negative offset");
    do_op(0, 1, 24'h010000, 11'h3FF, 0, "R1 max offset");
    do_op(0, 1, 24'h010000, 11'h400, 0, "R1 min offset");
    do_op(0, 1, 24'h000201, 11'h000, 0, "R4 lane1 load");
    do_op(0, 1, 24'h000202, 11'h000, 0, "R4 lane2 load");
    do_op(0, 1, 24'h000200, 11'h003, 0, "R3 lane3 load");
    do_op(0, 1, 24'hFFFFFD, 11'h000, 0, "R3 wrap load");
    do_op(1, 1, 24'h000300, 11'h000, 32'hA1B2C3D4, "R2 aligned store");
    do_op(0, 1, 24'h000300, 11'h000, 0, "R2 store readback");
    do_op(1, 1, 24'h000403, 11'h000, 32'h11223344, "R5 lane3 store");
    do_op(0, 1, 24'h000400, 11'h000, 0, "R5 low word untouched bytes");
    do_op(0, 1, 24'h000404, 11'h000, 0, "R5 high word untouched bytes");
    do_op(1, 1, 24'h000501, 11'h000, 32'hCAFEF00D, "R5 lane1 store");
    do_op(0, 1, 24'h000501, 11'h000, 0, "R5 lane1 readback");
    do_op(0, 0, 24'h000300, 11'h000, 0, "R6 squashed load");
    do_op(1, 0, 24'h000300, 11'h000, 32'h55555555, "R6 squashed store");
    do_op(0, 1, 24'h000300, 11'h000, 0, "R6 memory unchanged");
    do_op(0, 1, 24'h004000, 11'h000, 0, "R7 first-word load fault");
    do_op(0, 1, 24'h004001, 11'h000, 0, "R7 split first-half fault");
    do_op(1, 1, 24'h008002, 11'h000, 32'h77777777, "R7 store first-half fault");
    do_op(0, 1, 24'h003FFE, 11'h000, 0, "R8 split load second-half fault");
    do_op(1, 1, 24'h003FFD, 11'h000, 32'h99AABBCC, "R8 split store second-half fault");
    do_op(0, 1, 24'h003FFC, 11'h000, 0, "R8 first write kept");
    do_op(0, 1, 24'h000600, 11'h000, 0, "R9 back-to-back");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule